// File: doc/BRIEF.md
# Interleaved Dual-Bank Burst Bridge

This bridge sits between a byte-stream client and video memory built from two 32-bit banks. To the client the memory is one flat, byte-addressed 8 MiB space. Consecutive 32-bit words live in alternate banks: word address bit 0, which is byte address bit 2, picks the bank. A command gives a start address, a byte count and a direction. The bridge walks the burst one word at a time. It toggles the bank after every word, uses byte enables for the partial words at either end, and on the client side moves exactly the bytes that were asked for, in address order.

Before a write burst reaches memory, the bridge emits one invalidate notice for each 4 KiB page the burst covers. A cache of derived data elsewhere can use these notices to drop stale entries. Address bits above bit 22 are discarded. A burst that would run past the top of the space is cut short at the top.

Top module: `vram_split_bridge`

## Requirements
- R1: A command is taken when `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is high only while the bridge is idle. Only bits 22:0 of `cmd_addr` are used.
- R2: The effective length is the smaller of `cmd_len` and 0x800000 minus the masked address. No byte at or above 0x800000 is ever accessed.
- R3: Byte x of the flat space is at word w = x>>2 and lane x&3, where lane i is bits 8i+7:8i of the memory data. `mem_word_addr` is {w[0], w[20:1]}, so bank 1 starts 0x100000 words above bank 0.
- R4: The first word of a burst enables only the lanes from (addr&3) upward. It enables fewer lanes if the burst ends inside that word. Lanes outside the burst keep their stored bytes.
- R5: Each memory access after the first in a burst goes to the other bank from the access before it. The in-bank index advances after each bank-1 word. A burst makes exactly one access per word it touches.
- R6: When a burst ends part way into a later word, that word enables lanes 0 upward for the remaining bytes only.
- R7: For a write, `inv_valid` is high for one cycle per page index (address bits 22:12). The pages run in ascending order from the page of the first byte to the page of the last byte, and all of them come before the first memory write. A read emits no invalidate.
- R8: A read issues `mem_req` with `mem_we` low and samples `mem_rdata` on the next cycle. It then presents exactly the requested bytes on `rd_byte`, in ascending address order.
- R9: A zero-length command raises `done` on the following cycle, with no memory access and no invalidate.
- R10: `done` is high for exactly one cycle per command, after the last access of the burst.
- R11: While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_byte` hold. A write byte is consumed only in a cycle where both `wr_valid` and `wr_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Bridge idle, command can be taken |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_addr | input | 32 | Byte start address; bits 22:0 used |
| cmd_len | input | 24 | Byte count |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte accepted this cycle |
| wr_byte | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Client takes the read byte |
| rd_byte | output | 8 | Read byte |
| mem_req | output | 1 | Bank access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_word_addr | output | 21 | {bank, in-bank word index} |
| mem_be | output | 4 | Lane enables |
| mem_wdata | output | 32 | Write word |
| mem_rdata | input | 32 | Read word, valid the cycle after a read access |
| inv_valid | output | 1 | Page invalidate notice |
| inv_page | output | 11 | Page index being invalidated |
| done | output | 1 | Command finished |

## Verification
The assertions assume that memory accepts every access in the cycle it is issued and returns read data exactly one cycle later. The bench's bank model follows that timing. They also assume that the client keeps `wr_valid` and `wr_byte` steady until a byte is taken, which the bench's feeder task does even when it leaves gaps between bytes. Read back-pressure comes from a pseudo-random `rd_ready`. Every command is issued only while `cmd_ready` is high, so the burst-tracking state behind the bank-alternation and invalidate-ordering properties always starts from an idle bridge.

// File: rtl/vsb_pkg.sv
package vsb_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_INV,
        S_GATHER,
        S_WRITE,
        S_READ,
        S_RWAIT,
        S_SCATTER,
        S_FIN
    } vsb_state_e;

    typedef struct packed {
        logic [2:0] cnt;
        logic [3:0] be;
    } vsb_seg_t;

    // Lanes lo .. lo+cnt-1 of a 32-bit word.
    function automatic logic [3:0] lane_mask(input logic [1:0] lo, input logic [2:0] cnt);
        logic [7:0] ones;
        ones = (8'd1 << cnt) - 8'd1;
        return 4'(ones << lo);
    endfunction

endpackage

// File: rtl/vsb_cmd_prep.sv
module vsb_cmd_prep #(
    parameter int ADDR_W    = 23,
    parameter int PAGE_BITS = 12,
    localparam int LEN_W    = ADDR_W + 1,
    localparam int PAGE_W   = ADDR_W - PAGE_BITS
) (
    input  logic [31:0]       raw_addr,
    input  logic [LEN_W-1:0]  raw_len,
    output logic [ADDR_W-1:0] addr,
    output logic [LEN_W-1:0]  len_eff,
    output logic [PAGE_W-1:0] page_first,
    output logic [PAGE_W-1:0] page_last
);
    localparam logic [LEN_W-1:0] SPACE = LEN_W'(1) << ADDR_W;

    logic [LEN_W-1:0] room;
    logic [LEN_W-1:0] last_byte;

    always_comb begin
        addr       = raw_addr[ADDR_W-1:0];
        room       = SPACE - LEN_W'(addr);
        len_eff    = (raw_len > room) ? room : raw_len;
        last_byte  = LEN_W'(addr) + len_eff - LEN_W'(1);
        page_first = addr[ADDR_W-1:PAGE_BITS];
        page_last  = last_byte[ADDR_W-1:PAGE_BITS];
    end
endmodule

// File: rtl/vsb_page_walker.sv
module vsb_page_walker #(
    parameter int PAGE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [PAGE_W-1:0] first,
    input  logic [PAGE_W-1:0] last,
    output logic [PAGE_W-1:0] page,
    output logic              at_last
);
    logic [PAGE_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            page   <= '0;
            last_q <= '0;
        end else if (load) begin
            page   <= first;
            last_q <= last;
        end else if (step) begin
            page   <= page + PAGE_W'(1);
        end
    end

    assign at_last = (page == last_q);
endmodule

// File: rtl/vram_split_bridge.sv
module vram_split_bridge
    import vsb_pkg::*;
#(
    parameter int ADDR_W    = 23,
    parameter int PAGE_BITS = 12,
    localparam int LEN_W    = ADDR_W + 1,
    localparam int WORD_W   = ADDR_W - 2,
    localparam int PAGE_W   = ADDR_W - PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [31:0]       cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_byte,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [7:0]        rd_byte,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_word_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              inv_valid,
    output logic [PAGE_W-1:0] inv_page,
    output logic              done
);
    vsb_state_e        state;
    logic [WORD_W-1:0] waddr;
    logic [1:0]        lo;
    logic [1:0]        k;
    logic [LEN_W-1:0]  remain;
    logic [31:0]       dbuf;

    logic [ADDR_W-1:0] p_addr;
    logic [LEN_W-1:0]  p_len;
    logic [PAGE_W-1:0] p_pfirst, p_plast;
    logic              walk_last;
    logic              accept;

    vsb_seg_t          seg;
    logic [2:0]        room;
    logic [1:0]        lane;
    logic              lane_last;
    logic              seg_last;

    vsb_cmd_prep #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_prep (
        .raw_addr   (cmd_addr),
        .raw_len    (cmd_len),
        .addr       (p_addr),
        .len_eff    (p_len),
        .page_first (p_pfirst),
        .page_last  (p_plast)
    );

    assign accept = cmd_valid && (state == S_IDLE);

    vsb_page_walker #(.PAGE_W(PAGE_W)) u_walk (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .step    ((state == S_INV) && !walk_last),
        .first   (p_pfirst),
        .last    (p_plast),
        .page    (inv_page),
        .at_last (walk_last)
    );

    always_comb begin
        room      = 3'd4 - {1'b0, lo};
        seg.cnt   = (remain >= LEN_W'(room)) ? room : remain[2:0];
        seg.be    = lane_mask(lo, seg.cnt);
        lane      = lo + k;
        lane_last = ({1'b0, k} == (seg.cnt - 3'd1));
        seg_last  = (remain == LEN_W'(seg.cnt));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            waddr  <= '0;
            lo     <= '0;
            k      <= '0;
            remain <= '0;
            dbuf   <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (cmd_valid) begin
                    waddr  <= p_addr[ADDR_W-1:2];
                    lo     <= p_addr[1:0];
                    remain <= p_len;
                    k      <= '0;
                    dbuf   <= '0;
                    if (p_len == '0)    state <= S_FIN;
                    else if (cmd_write) state <= S_INV;
                    else                state <= S_READ;
                end
                S_INV: if (walk_last) state <= S_GATHER;
                S_GATHER: if (wr_valid) begin
                    dbuf[8*lane +: 8] <= wr_byte;
                    if (lane_last) state <= S_WRITE;
                    else           k     <= k + 2'd1;
                end
                S_WRITE: begin
                    remain <= remain - LEN_W'(seg.cnt);
                    waddr  <= waddr + WORD_W'(1);
                    lo     <= '0;
                    k      <= '0;
                    dbuf   <= '0;
                    state  <= seg_last ? S_FIN : S_GATHER;
                end
                S_READ:  state <= S_RWAIT;
                S_RWAIT: begin
                    dbuf  <= mem_rdata;
                    state <= S_SCATTER;
                end
                S_SCATTER: if (rd_ready) begin
                    if (lane_last) begin
                        remain <= remain - LEN_W'(seg.cnt);
                        waddr  <= waddr + WORD_W'(1);
                        lo     <= '0;
                        k      <= '0;
                        state  <= seg_last ? S_FIN : S_READ;
                    end else begin
                        k <= k + 2'd1;
                    end
                end
                S_FIN:   state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_ready     = (state == S_IDLE);
        wr_ready      = (state == S_GATHER);
        rd_valid      = (state == S_SCATTER);
        rd_byte       = dbuf[8*lane +: 8];
        mem_req       = (state == S_WRITE) || (state == S_READ);
        mem_we        = (state == S_WRITE);
        mem_word_addr = {waddr[0], waddr[WORD_W-1:1]};
        mem_be        = seg.be;
        mem_wdata     = dbuf;
        inv_valid     = (state == S_INV);
        done          = (state == S_FIN);
    end

    // Burst history used only by the properties below.
    logic chk_seen, chk_bank, chk_wrote;
    always_ff @(posedge clk) begin
        if (rst || state == S_IDLE) begin
            chk_seen  <= 1'b0;
            chk_bank  <= 1'b0;
            chk_wrote <= 1'b0;
        end else if (mem_req) begin
            chk_seen <= 1'b1;
            chk_bank <= mem_word_addr[WORD_W-1];
            if (mem_we) chk_wrote <= 1'b1;
        end
    end

    a_r5_bank_alternates: assert property (@(posedge clk) disable iff (rst)
        mem_req && chk_seen |-> mem_word_addr[WORD_W-1] != chk_bank);

    a_r7_inv_before_write: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> !chk_wrote);

    a_r7_pages_ascend: assert property (@(posedge clk) disable iff (rst)
        inv_valid && $past(inv_valid) |-> inv_page == $past(inv_page) + PAGE_W'(1));

    a_r4_be_contiguous: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_be inside {4'h1, 4'h3, 4'h7, 4'hF, 4'h2, 4'h6, 4'hE, 4'h4, 4'hC, 4'h8});

    a_r11_rd_hold: assert property (@(posedge clk) disable iff (rst)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_byte));

    a_r9_zero_len: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready && cmd_len == '0 |=> done && !mem_req && !inv_valid);

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && cmd_ready);
endmodule

// File: tb/vram_split_bridge_bench.sv
`timescale 1ns/1ps
module vram_split_bridge_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic [23:0] cmd_len = '0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_byte = '0;
    logic        rd_ready = 1'b1;
    logic        cmd_ready, wr_ready, rd_valid, mem_req, mem_we, inv_valid, done;
    logic [7:0]  rd_byte;
    logic [20:0] mem_word_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata, mem_rdata = '0;
    logic [10:0] inv_page;

    always #2.5 clk = ~clk;

    vram_split_bridge u_vram_split_bridge (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_byte(wr_byte),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_byte(rd_byte),
        .mem_req(mem_req), .mem_we(mem_we), .mem_word_addr(mem_word_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .inv_valid(inv_valid), .inv_page(inv_page), .done(done)
    );

    int checks = 0, fails = 0, cyc = 0;
    logic [31:0] bmem [int];
    int inv_q[$];
    logic [7:0] rd_q[$];
    int mem_cnt = 0, done_cnt = 0;
    bit stall = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [31:0] mword(int p);
        if (bmem.exists(p)) return bmem[p];
        return (p * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    function automatic int phys(int x);
        int w = x >> 2;
        return ((w & 1) << 20) | (w >> 1);
    endfunction

    function automatic logic [7:0] byte_at(int x);
        logic [31:0] w = mword(phys(x));
        return w[8*(x & 3) +: 8];
    endfunction

    function automatic logic [7:0] wpat(int x, int salt);
        return 8'((x * 37) ^ (x >> 7) ^ salt);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Bank model: accepts every access, read data one cycle later.
    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            logic [31:0] w;
            w = mword(int'(mem_word_addr));
            for (int i = 0; i < 4; i++)
                if (mem_be[i]) w[8*i +: 8] = mem_wdata[8*i +: 8];
            bmem[int'(mem_word_addr)] = w;
        end
        if (mem_req && !mem_we) mem_rdata <= mword(int'(mem_word_addr));
        lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rd_ready <= stall ? lfsr[0] : 1'b1;
    end

    // Monitor away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_req) mem_cnt++;
            if (inv_valid) inv_q.push_back(int'(inv_page));
            if (rd_valid && rd_ready) rd_q.push_back(rd_byte);
            if (done) done_cnt++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++; fails++;
            $display("FAIL R10 watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic burst(int raw, int len, bit we, int salt);
        int a = raw & 32'h7FFFFF;
        int eff = (len > 32'h800000 - a) ? 32'h800000 - a : len;
        int words = (eff == 0) ? 0 : (((a + eff - 1) >> 2) - (a >> 2) + 1);
        logic [7:0] before_lo, before_hi;
        before_lo = (a > 0) ? byte_at(a - 1) : 8'h0;
        before_hi = (a + eff < 32'h800000) ? byte_at(a + eff) : 8'h0;
        inv_q.delete(); rd_q.delete(); mem_cnt = 0; done_cnt = 0;
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_write = we; cmd_addr = raw; cmd_len = 24'(len);
        do @(negedge clk); while (!cmd_ready);
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        if (we) begin
            for (int k = 0; k < eff; k++) begin
                wr_valid = 1'b1; wr_byte = wpat(a + k, salt);
                do @(negedge clk); while (!wr_ready);
                @(posedge clk); #1;
                wr_valid = 1'b0;
                if (stall && (k & 1)) begin @(posedge clk); #1; end
            end
        end
        while (done_cnt == 0) @(negedge clk);
        @(negedge clk);
        chk(done_cnt == 1, "R10 done count", done_cnt, 1);
        chk(mem_cnt == words, "R5 access count", mem_cnt, words);
        if (we) begin
            int p0 = a >> 12;
            int np = (eff == 0) ? 0 : ((a + eff - 1) >> 12) - p0 + 1;
            chk(inv_q.size() == np, "R7 page count", inv_q.size(), np);
            foreach (inv_q[i]) chk(inv_q[i] == p0 + i, "R7 page order", inv_q[i], p0 + i);
            for (int k = 0; k < eff; k++)
                chk(byte_at(a + k) == wpat(a + k, salt), "R3 byte placement",
                    byte_at(a + k), wpat(a + k, salt));
            if (eff > 0 && (a & 3) != 0)
                chk(byte_at(a - 1) == before_lo, "R4 lane below burst kept", byte_at(a - 1), before_lo);
            if (eff > 0 && ((a + eff) & 3) != 0 && a + eff < 32'h800000)
                chk(byte_at(a + eff) == before_hi, "R6 lane above burst kept", byte_at(a + eff), before_hi);
        end else begin
            chk(inv_q.size() == 0, "R7 no invalidate on read", inv_q.size(), 0);
            chk(rd_q.size() == eff, "R8 read byte count", rd_q.size(), eff);
            foreach (rd_q[i])
                if (i < eff) chk(rd_q[i] == byte_at(a + i), "R8 R11 read byte", rd_q[i], byte_at(a + i));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R1 reset ready", cmd_ready, 1);
        chk(mem_req == 1'b0 && inv_valid == 1'b0, "R1 reset quiet", mem_req, 0);
        chk(rd_valid == 1'b0 && done == 1'b0, "R10 reset idle", done, 0);

        // Sweep of start offsets and lengths around a page boundary.
        for (int o = 0; o < 8; o++) begin
            for (int len = 0; len <= 12; len++) begin
                stall = ((o + len) % 3) == 0;   // R11 back-pressure on both streams
                burst(32'h3FF8 + o, len, 1'b1, o * 13 + len);
                burst(32'h3FF8 + o, len, 1'b0, 0);
            end
        end
        stall = 1'b0;

        // R9: zero length, no access at all.
        burst(32'h123, 0, 1'b1, 5);
        chk(mem_cnt == 0 && inv_q.size() == 0, "R9 zero length quiet", mem_cnt, 0);

        // R1: upper address bits discarded.
        burst(32'hABC00021, 9, 1'b1, 77);
        burst(32'h00400021, 9, 1'b0, 0);

        // R2: burst clipped at the top of the space.
        burst(32'h7FFFFA, 20, 1'b1, 99);
        chk(mem_cnt == 2, "R2 clipped access count", mem_cnt, 2);
        burst(32'h7FFFFA, 20, 1'b0, 0);
        chk(rd_q.size() == 6, "R2 clipped read length", rd_q.size(), 6);

        // Long write across two pages, read back with stalls.
        burst(32'h5FF3, 40, 1'b1, 3);
        stall = 1'b1;
        burst(32'h5FF3, 40, 1'b0, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule